// File: doc/BRIEF.md
# Serial Transmit Line Encoder

This block turns a serial bit stream from an upstream framer into the level driven on a transmit data line. On every bit period it takes one data bit and a frame-active flag. It then shapes the line with one of six codes: non-return-to-zero, NRZI, two frequency-modulation variants (FM0, FM1), Manchester and Differential Manchester. The block runs from an oversampled clock. A two-bit rate code sets how many clocks make up one bit period, and a registered request strobe tells the framer when to present the next bit.

Between frames the line either rests high or carries encoded ones, depending on an idle-mode input. A biphase code needs a mid-bit transition, so it cannot work at the 1x rate. Any setting that is not allowed makes the block fall back to plain NRZ and raise a configuration-error flag.

Top module: `txline_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `txd` = 1, `bit_req` = 1 and `cfg_err` = 0.
- R2: `div_sel` 2'b00, 2'b01, 2'b10 and 2'b11 give a bit period of 1, RATE_LO, RATE_MID and RATE_HI clocks. `bit_req` is high for exactly one cycle per period, and that cycle is the last one before the period begins.
- R3: `line_code` 3'd0 (NRZ) drives the sampled bit on `txd` for the whole period.
- R4: `line_code` 3'd1 (NRZI) inverts `txd` at the start of a period for a 0 bit and holds it for a 1 bit.
- R5: `line_code` 3'd2 (FM0) inverts `txd` at every period start, and also at mid-period for a 0 bit.
- R6: `line_code` 3'd3 (FM1) inverts `txd` at every period start, and also at mid-period for a 1 bit.
- R7: `line_code` 3'd4 (Manchester) drives a 1 bit as high then low, and a 0 bit as low then high.
- R8: `line_code` 3'd5 (Differential Manchester) inverts `txd` at mid-period for every bit, and at the period start for a 0 bit only.
- R9: In an oversampled mode with period N, the start-of-period level holds for the first N/2 clocks of the period and the mid-period level holds for the remaining N/2.
- R10: With `idle_enc` = 0, a period sampled with `frame_active` = 0 keeps `txd` high for the whole period. Later encoding continues from that high level.
- R11: With `idle_enc` = 1, a period sampled with `frame_active` = 0 is encoded as a 1 bit with the selected code.
- R12: `line_code` 3'd6 or 3'd7, or 1x rate with a `line_code` from 3'd2 to 3'd5, is illegal. An illegal setting encodes as NRZ and holds `cfg_err` high from the cycle after. A legal setting holds `cfg_err` low.
- R13: `bit_in` and `frame_active` are sampled only at the clock edge that ends a cycle with `bit_req` high. Changes at any other time have no effect on `txd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | 2 | Rate code: 1x, RATE_LO, RATE_MID, RATE_HI clocks per bit |
| line_code | input | 3 | Line code select (0 NRZ, 1 NRZI, 2 FM0, 3 FM1, 4 Manchester, 5 Differential Manchester) |
| idle_enc | input | 1 | 0: rest high between frames; 1: send encoded ones between frames |
| bit_in | input | 1 | Serial data bit from the framer |
| frame_active | input | 1 | High while the framer is sending frame content |
| txd | output | 1 | Encoded transmit line, registered |
| bit_req | output | 1 | Next-bit request strobe, registered |
| cfg_err | output | 1 | Illegal rate/code combination flag, registered |

## Verification
The bench builds the encoder with RATE_LO = 4, RATE_MID = 6 and RATE_HI = 10 in place of the 8/16/32 defaults. Short periods let each configuration run many bit periods within the cycle budget. A period of 6 puts the mid-period edge at clock 3, which is not a power of two, so a half-period counter that assumes power-of-two rates would be caught. Every rate, every code value including the two illegal ones, and both idle modes are swept, and the framer inputs are scrambled during non-sampling cycles.

// File: rtl/txenc_pkg.sv
package txenc_pkg;

  typedef enum logic [2:0] {
    LC_NRZ  = 3'd0,
    LC_NRZI = 3'd1,
    LC_FM0  = 3'd2,
    LC_FM1  = 3'd3,
    LC_MAN  = 3'd4,
    LC_DMAN = 3'd5
  } line_code_e;

  typedef enum logic [1:0] {
    DIV_1X  = 2'd0,
    DIV_LO  = 2'd1,
    DIV_MID = 2'd2,
    DIV_HI  = 2'd3
  } div_sel_e;

endpackage

// File: rtl/txenc_cfg_check.sv
module txenc_cfg_check
  import txenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] div_sel,
  input  logic [2:0] code_raw,
  output line_code_e code_eff,
  output logic       cfg_err
);

  logic illegal;
  logic err_q;

  always_comb begin
    illegal  = 1'b0;
    code_eff = LC_NRZ;
    case (code_raw)
      3'd0: code_eff = LC_NRZ;
      3'd1: code_eff = LC_NRZI;
      3'd2, 3'd3, 3'd4, 3'd5: begin
        if (div_sel == DIV_1X) illegal = 1'b1;
        else                   code_eff = line_code_e'(code_raw);
      end
      default: illegal = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= illegal;
  end

  assign cfg_err = err_q;

  // R12
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ((div_sel == 2'd0 && code_raw >= 3'd2) || code_raw >= 3'd6) |=> cfg_err);

  // R12
  legal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (code_raw <= 3'd1 || (div_sel != 2'd0 && code_raw <= 3'd5)) |=> !cfg_err);

endmodule

// File: rtl/txenc_bit_timer.sv
module txenc_bit_timer
  import txenc_pkg::*;
#(
  parameter int RATE_LO  = 8,
  parameter int RATE_MID = 16,
  parameter int RATE_HI  = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] div_sel,
  output logic       bit_start,
  output logic       mid_pt,
  output logic       bit_req
);

  localparam int CNT_W = $clog2(RATE_HI + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] rate_n;
  logic [CNT_W-1:0] half_n;
  logic             req_q;
  logic             last;

  always_comb begin
    case (div_sel)
      DIV_LO:  rate_n = CNT_W'(RATE_LO);
      DIV_MID: rate_n = CNT_W'(RATE_MID);
      DIV_HI:  rate_n = CNT_W'(RATE_HI);
      default: rate_n = CNT_W'(1);
    endcase
  end

  assign half_n    = rate_n >> 1;
  assign last      = (cnt_q >= rate_n - CNT_W'(1));
  assign cnt_nxt   = last ? '0 : cnt_q + CNT_W'(1);
  assign bit_start = (cnt_q == '0);
  assign mid_pt    = (rate_n > CNT_W'(1)) && (cnt_q == half_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      req_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      req_q <= (cnt_nxt == '0);
    end
  end

  assign bit_req = req_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(div_sel) |-> (cnt_q < rate_n));

  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_req && div_sel != 2'd0) |=> (!bit_req || div_sel != $past(div_sel)));

endmodule

// File: rtl/txenc_shaper.sv
module txenc_shaper
  import txenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  line_code_e code_eff,
  input  logic       idle_enc,
  input  logic       bit_start,
  input  logic       mid_pt,
  input  logic       bit_in,
  input  logic       frame_active,
  output logic       txd
);

  logic line_q;
  logic mid_q;
  logic eff_bit;
  logic rest_high;
  logic bnd_lvl;
  logic mid_lvl;

  assign eff_bit   = frame_active ? bit_in : 1'b1;
  assign rest_high = !frame_active && !idle_enc;

  always_comb begin
    bnd_lvl = eff_bit;
    mid_lvl = eff_bit;
    case (code_eff)
      LC_NRZI: begin
        bnd_lvl = eff_bit ? line_q : ~line_q;
        mid_lvl = bnd_lvl;
      end
      LC_FM0: begin
        bnd_lvl = ~line_q;
        mid_lvl = eff_bit ? bnd_lvl : ~bnd_lvl;
      end
      LC_FM1: begin
        bnd_lvl = ~line_q;
        mid_lvl = eff_bit ? ~bnd_lvl : bnd_lvl;
      end
      LC_MAN: begin
        bnd_lvl = eff_bit;
        mid_lvl = ~eff_bit;
      end
      LC_DMAN: begin
        bnd_lvl = eff_bit ? line_q : ~line_q;
        mid_lvl = ~bnd_lvl;
      end
      default: begin
        bnd_lvl = eff_bit;
        mid_lvl = eff_bit;
      end
    endcase
    if (rest_high) begin
      bnd_lvl = 1'b1;
      mid_lvl = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b1;
      mid_q  <= 1'b1;
    end else if (bit_start) begin
      line_q <= bnd_lvl;
      mid_q  <= mid_lvl;
    end else if (mid_pt) begin
      line_q <= mid_q;
    end
  end

  assign txd = line_q;

  // R5 R6
  biphase_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_start && frame_active && (code_eff == LC_FM0 || code_eff == LC_FM1))
      |=> (txd != $past(txd)));

  // R7
  man_first_half_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_start && frame_active && code_eff == LC_MAN) |=> (txd == $past(bit_in)));

  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_start && !frame_active && !idle_enc) |=> txd);

  // R9
  quiet_between_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_start && !mid_pt) |=> $stable(txd));

endmodule

// File: rtl/txline_encoder.sv
module txline_encoder
  import txenc_pkg::*;
#(
  parameter int RATE_LO  = 8,
  parameter int RATE_MID = 16,
  parameter int RATE_HI  = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] div_sel,
  input  logic [2:0] line_code,
  input  logic       idle_enc,
  input  logic       bit_in,
  input  logic       frame_active,
  output logic       txd,
  output logic       bit_req,
  output logic       cfg_err
);

  line_code_e code_eff;
  logic       bit_start;
  logic       mid_pt;

  txenc_cfg_check u_cfg (
    .clk      (clk),
    .rst      (rst),
    .div_sel  (div_sel),
    .code_raw (line_code),
    .code_eff (code_eff),
    .cfg_err  (cfg_err)
  );

  txenc_bit_timer #(
    .RATE_LO  (RATE_LO),
    .RATE_MID (RATE_MID),
    .RATE_HI  (RATE_HI)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .div_sel   (div_sel),
    .bit_start (bit_start),
    .mid_pt    (mid_pt),
    .bit_req   (bit_req)
  );

  txenc_shaper u_shape (
    .clk          (clk),
    .rst          (rst),
    .code_eff     (code_eff),
    .idle_enc     (idle_enc),
    .bit_start    (bit_start),
    .mid_pt       (mid_pt),
    .bit_in       (bit_in),
    .frame_active (frame_active),
    .txd          (txd)
  );

  // R1
  reset_line_chk: assert property (@(posedge clk) rst |=> (txd && bit_req && !cfg_err));

endmodule

// File: tb/txline_encoder_test.sv
module txline_encoder_test;

  localparam int RL = 4;
  localparam int RM = 6;
  localparam int RH = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] div_sel = 2'd0;
  logic [2:0] line_code = 3'd0;
  logic       idle_enc = 1'b0;
  logic       bit_in = 1'b0;
  logic       frame_active = 1'b0;
  logic       txd;
  logic       bit_req;
  logic       cfg_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  txline_encoder #(.RATE_LO(RL), .RATE_MID(RM), .RATE_HI(RH)) uut (
    .clk          (clk),
    .rst          (rst),
    .div_sel      (div_sel),
    .line_code    (line_code),
    .idle_enc     (idle_enc),
    .bit_in       (bit_in),
    .frame_active (frame_active),
    .txd          (txd),
    .bit_req      (bit_req),
    .cfg_err      (cfg_err)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rate_of(int d);
    case (d)
      1: return RL;
      2: return RM;
      3: return RH;
      default: return 1;
    endcase
  endfunction

  function automatic bit legal(int d, int c);
    return (c <= 1) || (c <= 5 && d != 0);
  endfunction

  // returns {start-of-period level, mid-period level}
  function automatic logic [1:0] encode(int code, bit b, bit a, bit idle, logic prev);
    logic eb, bnd, mid;
    eb = a ? b : 1'b1;
    if (!a && !idle) return 2'b11;
    case (code)
      1: begin bnd = eb ? prev : ~prev; mid = bnd; end
      2: begin bnd = ~prev; mid = eb ? bnd : ~bnd; end
      3: begin bnd = ~prev; mid = eb ? ~bnd : bnd; end
      4: begin bnd = eb; mid = ~eb; end
      5: begin bnd = eb ? prev : ~prev; mid = ~bnd; end
      default: begin bnd = eb; mid = eb; end
    endcase
    return {bnd, mid};
  endfunction

  function automatic string tag_of(int code, bit a, bit idle, bit lg);
    if (!lg) return "R12";
    if (!a) return idle ? "R11" : "R10";
    case (code)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R3";
    endcase
  endfunction

  // mode 0: random bits, 1: all zeros in frame, 2: all ones in frame
  task automatic run_cfg(int d, int c, bit idle, int nbits, int mode);
    int n;
    bit lg;
    int ce;
    logic prev;
    logic [1:0] lv;
    bit b, a;
    string tg;
    @(negedge clk);
    rst = 1'b1;
    div_sel = 2'(d);
    line_code = 3'(c);
    idle_enc = idle;
    bit_in = 1'b0;
    frame_active = 1'b0;
    @(negedge clk);
    chk("R1 txd in reset", txd, 1'b1);
    chk("R1 bit_req in reset", bit_req, 1'b1);
    chk("R1 cfg_err in reset", cfg_err, 1'b0);
    rst = 1'b0;
    n = rate_of(d);
    lg = legal(d, c);
    ce = lg ? c : 0;
    prev = 1'b1;
    for (int k = 0; k < nbits; k++) begin
      chk("R2 bit_req at period end", bit_req, 1'b1);
      if (mode == 1)      b = 1'b0;
      else if (mode == 2) b = 1'b1;
      else                b = 1'($urandom % 2);
      a = (mode != 0) ? 1'b1 : (($urandom % 4) != 0);
      bit_in = b;
      frame_active = a;
      lv = encode(ce, b, a, idle, prev);
      tg = tag_of(ce, a, idle, lg);
      for (int j = 1; j <= n; j++) begin
        @(negedge clk);
        if (j == 1) chk("R12 cfg_err level", cfg_err, !lg);
        if (n == 1 || j <= n / 2)
          chk($sformatf("%s R9 R13 first half d=%0d c=%0d bit=%0d ph=%0d", tg, d, c, k, j), txd, lv[1]);
        else
          chk($sformatf("%s R9 R13 second half d=%0d c=%0d bit=%0d ph=%0d", tg, d, c, k, j), txd, lv[0]);
        if (j < n) begin
          chk("R2 bit_req low inside period", bit_req, 1'b0);
          // R13: scramble inputs outside the sampling cycle
          bit_in = 1'($urandom % 2);
          frame_active = 1'($urandom % 2);
        end
      end
      prev = lv[0];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int d = 0; d < 4; d++)
      for (int c = 0; c < 8; c++)
        for (int i = 0; i < 2; i++)
          run_cfg(d, c, i[0], 12, 0);
    // directed corners: long zero and one runs for each biphase code
    for (int c = 1; c < 6; c++) begin
      run_cfg(2, c, 1'b0, 6, 1);
      run_cfg(3, c, 1'b1, 6, 2);
    end
    run_cfg(0, 1, 1'b1, 8, 1);
    run_cfg(0, 4, 1'b0, 4, 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule